// File: doc/BRIEF.md
# Task-Switched Memory Map Unit

This block sits between a CPU with a 16-bit logical address space and a much larger physical memory. The logical space is split into eight 8 KB slots. Each slot is translated through a map entry chosen by the current task number, a secondary task number and the slot number. One write to the task register switches the whole set of eight entries at once, so an operating system can change address spaces without reloading individual entries.

Each 16-bit map entry holds a 13-bit physical frame number and three access flags. An access that breaks a flag rule is refused: the memory strobe stays low and a registered fault with a cause code is raised instead. When the shared area is enabled, the topmost logical slot bypasses the per-task entries and lands on one fixed frame. All tasks then see the same memory there, which suits message passing and shared kernel data.

Configuration is written through a small register port that has a two-bit selector. Translation results appear one clock after the bus request.

Top module: `mmu_task_map`

## Requirements
- R1: After reset the task and secondary task numbers are zero, the shared area is disabled, and mem_strobe and fault are low. The entries for task 0 with secondary index 0 map slot n to frame n with only the valid flag set, which is an identity map of the low 64 KB. All other entries are cleared, and therefore invalid.
- R2: One clock after a cycle with bus_req high, phys_addr equals {entry frame, bus_la[12:0]}. The entry is found at index {low SEC_IDX_W bits of the secondary task, task, bus_la[15:13]}. Entry layout: bit 15 is write protect, bit 14 is valid, bit 13 is no-execute, and bits 12:0 are the frame.
- R3: A register write with reg_sel=0 loads the task number from reg_wdata[4:0]. A bus request made in the same clock as this write is still translated with the old task. Requests from the next clock on use the new task.
- R4: A register write with reg_sel=1 loads the secondary task number from reg_wdata[6:0]. Only its low SEC_IDX_W bits (default 1) take part in the index, so secondary values 1 and 3 select the same entries.
- R5: A denied access drives fault high and mem_strobe low one clock after the request, with fault_code giving the cause. Code 1 means the entry is not valid. Code 2 means a write to a write-protected entry. Code 3 means a fetch (bus_fetch high) from a no-execute entry. When several causes apply, code 1 wins over code 2, and code 2 wins over code 3. A read that is not a fetch is never refused by the write-protect or no-execute flags.
- R6: A register write with reg_sel=2 sets the shared-area enable from reg_wdata[15] and the shared frame from reg_wdata[12:0]. While the shared area is enabled, any access to slot 7 maps to that frame, whatever the task and whatever the flags of the entry, and it never faults.
- R7: A register write with reg_sel=3 stores reg_wdata into the map entry at index reg_addr, laid out as {secondary bits, task, slot}. Only that entry changes.
- R8: mem_strobe and fault are high only in the clock after a bus request, and never both at once. With no request, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Configuration write strobe |
| reg_sel | input | 2 | Target: 0 task, 1 secondary task, 2 shared area, 3 map entry |
| reg_addr | input | 9 | Map entry index {secondary bits, task, slot} for reg_sel=3 |
| reg_wdata | input | 16 | Configuration write data |
| bus_req | input | 1 | CPU access request |
| bus_we | input | 1 | Access is a write |
| bus_fetch | input | 1 | Access is an instruction fetch |
| bus_la | input | 16 | Logical address |
| mem_strobe | output | 1 | Registered: granted access, physical address valid |
| phys_addr | output | 26 | Registered physical address |
| fault | output | 1 | Registered: access denied |
| fault_code | output | 2 | Cause of the fault, 0 when none |

## Verification
A corrupted task or secondary register shows up on the very next request as a physical frame from the wrong map set, or as an unexpected invalid fault. The wrong frame is visible in phys_addr one clock after the request. A bad map entry or a wrong index field appears as a wrong frame, or as a wrong fault code, on the first access to that slot. A stale or early task switch is caught by a request placed in the same clock as the task write. A broken shared-area path is caught by accesses to slot 7 under a task whose own entry there is invalid.

// File: rtl/mmu_task_pkg.sv
package mmu_task_pkg;
  localparam int ENTRY_W = 16;
  localparam int FRAME_W = 13;

  typedef enum logic [1:0] {
    SEL_TASK   = 2'd0,
    SEL_SEC    = 2'd1,
    SEL_COMMON = 2'd2,
    SEL_MAP    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_WPROT   = 2'd2,
    FLT_NOEXEC  = 2'd3
  } fault_e;

  typedef struct packed {
    logic               wprot;
    logic               valid;
    logic               noexec;
    logic [FRAME_W-1:0] frame;
  } map_entry_t;

  // Priority of causes: invalid, then write protect, then no-execute.
  function automatic fault_e access_check(map_entry_t e, logic we, logic fetch);
    if (!e.valid)           return FLT_INVALID;
    else if (we && e.wprot) return FLT_WPROT;
    else if (fetch && e.noexec) return FLT_NOEXEC;
    else                    return FLT_NONE;
  endfunction

  // Entry value after reset: identity map for the first slots, invalid elsewhere.
  function automatic map_entry_t boot_entry(int idx, int slots);
    map_entry_t e;
    e = '0;
    if (idx < slots) begin
      e.valid = 1'b1;
      e.frame = FRAME_W'(idx);
    end
    return e;
  endfunction
endpackage

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_task_pkg::*;
#(
  parameter int TASK_W = 5,
  parameter int SEC_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [1:0]         sel,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [TASK_W-1:0]  task_q,
  output logic [SEC_W-1:0]   sec_q,
  output logic               common_en,
  output logic [FRAME_W-1:0] common_base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_q      <= '0;
      sec_q       <= '0;
      common_en   <= 1'b0;
      common_base <= '0;
    end else if (wr) begin
      case (reg_sel_e'(sel))
        SEL_TASK:   task_q <= wdata[TASK_W-1:0];
        SEL_SEC:    sec_q  <= wdata[SEC_W-1:0];
        SEL_COMMON: begin
          common_en   <= wdata[ENTRY_W-1];
          common_base <= wdata[FRAME_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mmu_map_table.sv
module mmu_map_table
  import mmu_task_pkg::*;
#(
  parameter int AW    = 9,
  parameter int SLOTS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  map_entry_t    wdata,
  input  logic [AW-1:0] raddr,
  output map_entry_t    rdata
);
  localparam int DEPTH = 1 << AW;

  map_entry_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[i] <= boot_entry(i, SLOTS);
      else if (wr && waddr == AW'(i))       mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_task_pkg::*;
#(
  parameter int LA_W   = 16,
  parameter int SLOT_W = 3,
  parameter int PA_W   = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic               fetch,
  input  logic [LA_W-1:0]    la,
  input  map_entry_t         entry,
  input  logic               common_en,
  input  logic [FRAME_W-1:0] common_base,
  output logic               common_hit,
  output logic               strobe,
  output logic [PA_W-1:0]    phys,
  output logic               fault,
  output logic [1:0]         fault_code
);
  localparam int PAGE_W = LA_W - SLOT_W;

  fault_e             cause;
  logic [FRAME_W-1:0] frame_sel;

  assign common_hit = common_en && (la[LA_W-1 -: SLOT_W] == {SLOT_W{1'b1}});
  assign cause      = common_hit ? FLT_NONE : access_check(entry, we, fetch);
  assign frame_sel  = common_hit ? common_base : entry.frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe     <= 1'b0;
      phys       <= '0;
      fault      <= 1'b0;
      fault_code <= '0;
    end else begin
      strobe     <= req && (cause == FLT_NONE);
      fault      <= req && (cause != FLT_NONE);
      fault_code <= req ? cause : FLT_NONE;
      if (req) phys <= {frame_sel, la[PAGE_W-1:0]};
    end
  end
endmodule

// File: rtl/mmu_task_map.sv
module mmu_task_map
  import mmu_task_pkg::*;
#(
  parameter int TASK_W    = 5,
  parameter int SEC_W     = 7,
  parameter int SEC_IDX_W = 1,
  parameter int LA_W      = 16,
  parameter int SLOT_W    = 3,
  parameter int TBL_AW    = SEC_IDX_W + TASK_W + SLOT_W,
  parameter int PA_W      = FRAME_W + LA_W - SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [TBL_AW-1:0]  reg_addr,
  input  logic [ENTRY_W-1:0] reg_wdata,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic               bus_fetch,
  input  logic [LA_W-1:0]    bus_la,
  output logic               mem_strobe,
  output logic [PA_W-1:0]    phys_addr,
  output logic               fault,
  output logic [1:0]         fault_code
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [TASK_W-1:0]  task_q;
  logic [SEC_W-1:0]   sec_q;
  logic               common_en;
  logic [FRAME_W-1:0] common_base;
  logic [TBL_AW-1:0]  look_idx;
  map_entry_t         look_entry;
  logic               common_hit;
  logic               map_wr;

  assign map_wr   = reg_wr && (reg_sel_e'(reg_sel) == SEL_MAP);
  assign look_idx = {sec_q[SEC_IDX_W-1:0], task_q, bus_la[LA_W-1 -: SLOT_W]};

  mmu_ctrl_regs #(.TASK_W(TASK_W), .SEC_W(SEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .task_q(task_q), .sec_q(sec_q), .common_en(common_en), .common_base(common_base)
  );

  mmu_map_table #(.AW(TBL_AW), .SLOTS(SLOTS)) u_table (
    .clk(clk), .rst_n(rst_n), .wr(map_wr), .waddr(reg_addr),
    .wdata(map_entry_t'(reg_wdata)), .raddr(look_idx), .rdata(look_entry)
  );

  mmu_xlate #(.LA_W(LA_W), .SLOT_W(SLOT_W), .PA_W(PA_W)) u_xlate (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .fetch(bus_fetch),
    .la(bus_la), .entry(look_entry), .common_en(common_en),
    .common_base(common_base), .common_hit(common_hit), .strobe(mem_strobe),
    .phys(phys_addr), .fault(fault), .fault_code(fault_code)
  );
endmodule

// File: rtl/mmu_task_map_chk.sv
module mmu_task_map_chk
  import mmu_task_pkg::*;
#(
  parameter int TASK_W = 5,
  parameter int LA_W   = 16,
  parameter int PA_W   = 26,
  parameter int PAGE_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [1:0]         reg_sel,
  input logic [ENTRY_W-1:0] reg_wdata,
  input logic               bus_req,
  input logic               bus_we,
  input logic [LA_W-1:0]    bus_la,
  input logic               mem_strobe,
  input logic [PA_W-1:0]    phys_addr,
  input logic               fault,
  input logic [1:0]         fault_code,
  input logic [TASK_W-1:0]  task_q,
  input logic               common_hit,
  input logic [FRAME_W-1:0] common_base,
  input map_entry_t         look_entry
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_strobe && fault));

  assert_only_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !bus_req |=> !mem_strobe && !fault);

  assert_answer_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    bus_req |=> mem_strobe || fault);

  assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    bus_req |=> phys_addr[PAGE_W-1:0] == $past(bus_la[PAGE_W-1:0]));

  assert_common_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (bus_req && common_hit) |=> mem_strobe && phys_addr[PA_W-1 -: FRAME_W] == $past(common_base));

  assert_task_load_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (reg_wr && reg_sel == 2'd0) |=> task_q == $past(reg_wdata[TASK_W-1:0]));

  assert_wprot_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (bus_req && bus_we && !common_hit && look_entry.valid && look_entry.wprot)
      |=> fault && fault_code == 2'd2);
endmodule

bind mmu_task_map mmu_task_map_chk #(
  .TASK_W(TASK_W), .LA_W(LA_W), .PA_W(PA_W), .PAGE_W(LA_W - SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_we(bus_we), .bus_la(bus_la),
  .mem_strobe(mem_strobe), .phys_addr(phys_addr), .fault(fault),
  .fault_code(fault_code), .task_q(task_q), .common_hit(common_hit),
  .common_base(common_base), .look_entry(look_entry)
);

// File: tb/mmu_task_map_bench.sv
module mmu_task_map_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [8:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_fetch = 1'b0;
  logic [15:0] bus_la = '0;
  logic        mem_strobe;
  logic [25:0] phys_addr;
  logic        fault;
  logic [1:0]  fault_code;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mmu_task_map u_mmu_task_map (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_fetch(bus_fetch), .bus_la(bus_la),
    .mem_strobe(mem_strobe), .phys_addr(phys_addr), .fault(fault),
    .fault_code(fault_code)
  );

  function automatic logic [25:0] mk_phys(logic [12:0] frame, logic [15:0] la);
    return {frame, la[12:0]};
  endfunction

  function automatic logic [15:0] mk_entry(bit wp, bit v, bit nx, logic [12:0] fr);
    return {wp, v, nx, fr};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] sel, logic [8:0] addr, logic [15:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Issue one access; the result is registered at the next edge and sampled on the falling edge after it.
  task automatic access(logic [15:0] la, bit we, bit fe);
    @(negedge clk);
    bus_req = 1'b1; bus_la = la; bus_we = we; bus_fetch = fe;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_fetch = 1'b0;
  endtask

  task automatic expect_ok(string req, logic [15:0] la, bit we, bit fe, logic [12:0] frame);
    access(la, we, fe);
    check({req, " strobe"}, 32'(mem_strobe), 32'd1);
    check({req, " fault"}, 32'(fault), 32'd0);
    check({req, " phys"}, 32'(phys_addr), 32'(mk_phys(frame, la)));
  endtask

  task automatic expect_fault(string req, logic [15:0] la, bit we, bit fe, logic [1:0] code);
    access(la, we, fe);
    check({req, " strobe"}, 32'(mem_strobe), 32'd0);
    check({req, " fault"}, 32'(fault), 32'd1);
    check({req, " code"}, 32'(fault_code), 32'(code));
  endtask

  task automatic t_reset;
    check("R1 reset strobe", 32'(mem_strobe), 32'd0);
    check("R1 reset fault", 32'(fault), 32'd0);
    expect_ok("R1 identity slot2", 16'h4567, 0, 0, 13'd2);
    expect_ok("R1 identity slot7", 16'hFFFE, 1, 1, 13'd7);
    @(negedge clk);
    check("R8 idle strobe", 32'(mem_strobe), 32'd0);
    check("R8 idle fault", 32'(fault), 32'd0);
  endtask

  task automatic t_task_map;
    // task 3, slot 2: index {0, 3, 2}
    reg_write(2'd3, {1'b0, 5'd3, 3'd2}, mk_entry(0, 1, 0, 13'h1ABC));
    reg_write(2'd3, {1'b0, 5'd3, 3'd4}, mk_entry(1, 1, 0, 13'h0042));
    reg_write(2'd3, {1'b0, 5'd3, 3'd5}, mk_entry(0, 1, 1, 13'h0ABC));
    reg_write(2'd3, {1'b0, 5'd3, 3'd6}, mk_entry(1, 0, 1, 13'h0001));
    expect_ok("R7 task0 untouched", 16'h5123, 0, 0, 13'd2);
    reg_write(2'd0, 9'd0, 16'd3);
    expect_ok("R2 task3 slot2", 16'h5123, 0, 0, 13'h1ABC);
    expect_fault("R5 invalid slot0", 16'h0010, 0, 0, 2'd1);
    expect_fault("R5 write protect", 16'h8001, 1, 0, 2'd2);
    expect_ok("R5 read of wp slot", 16'h8001, 0, 0, 13'h0042);
    expect_fault("R5 noexec fetch", 16'hA100, 0, 1, 2'd3);
    expect_ok("R5 write noexec slot", 16'hA100, 1, 0, 13'h0ABC);
    expect_fault("R5 priority invalid", 16'hC000, 1, 1, 2'd1);
  endtask

  task automatic t_switch_same_cycle;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'd0;
    bus_req = 1'b1; bus_la = 16'h5123; bus_we = 1'b0; bus_fetch = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; bus_req = 1'b0;
    check("R3 same-cycle old task", 32'(phys_addr), 32'(mk_phys(13'h1ABC, 16'h5123)));
    expect_ok("R3 new task next", 16'h5123, 0, 0, 13'd2);
  endtask

  task automatic t_secondary;
    reg_write(2'd3, {1'b1, 5'd0, 3'd1}, mk_entry(0, 1, 0, 13'h0777));
    reg_write(2'd1, 9'd0, 16'd1);
    expect_ok("R4 sec1 slot1", 16'h2010, 0, 0, 13'h0777);
    expect_fault("R4 sec1 slot0 invalid", 16'h0000, 0, 0, 2'd1);
    reg_write(2'd1, 9'd0, 16'd3);
    expect_ok("R4 sec3 aliases sec1", 16'h2010, 0, 0, 13'h0777);
    reg_write(2'd1, 9'd0, 16'd0);
    expect_ok("R4 sec0 identity", 16'h2010, 0, 0, 13'd1);
  endtask

  task automatic t_common;
    reg_write(2'd0, 9'd0, 16'd3);
    expect_fault("R6 slot7 invalid before", 16'hE004, 0, 0, 2'd1);
    reg_write(2'd2, 9'd0, 16'h8000 | 16'h1F00);
    expect_ok("R6 common write task3", 16'hE004, 1, 1, 13'h1F00);
    reg_write(2'd0, 9'd9, 16'd9);
    expect_ok("R6 common task9", 16'hFFFF, 0, 0, 13'h1F00);
    expect_fault("R6 other slot still mapped", 16'hC000, 0, 0, 2'd1);
    reg_write(2'd2, 9'd0, 16'h0000);
    expect_fault("R6 disabled", 16'hE004, 0, 0, 2'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_task_map();
    t_switch_same_cycle();
    t_secondary();
    t_common();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule